// File: doc/BRIEF.md
# I2C Controller Register Interface

This block is the software-visible register file that sits between a processor bus and an I2C protocol engine. It holds a control register, a status register, a data register and a slave-address register. The control register cannot be written directly. One bus offset sets bits and another clears them, so software can change single bits without a read-modify-write sequence. The status register holds a 5-bit bus-state code that the engine supplies. The code is captured only at the moment the interrupt flag rises. It then stays frozen until software clears the flag.

Everything the engine needs goes out on a sideband port: the control bits, the byte to transmit, the own slave address and the general-call enable. The engine gives back a status code, a one-cycle interrupt request and a receive-byte load strobe. The bus port is combinational on reads and registered on writes. The interrupt output is the pending flag qualified by the interface-enable control bit. The bit-level I2C state machine and the bit-rate logic live elsewhere.

Top module: `i2c_regif`

## Requirements
- R1: After reset the control, data and address registers read 0x00, the status register reads 0xF8, and `irq` is low.
- R2: A bus write to offset 0x00 sets each control bit whose position in `bus_wdata[4:0]` holds a one and leaves the others unchanged. The control bits are: bit 0 ack enable, bit 1 interrupt flag, bit 2 stop request, bit 3 start request, bit 4 interface enable.
- R3: A bus write to offset 0x18 clears each control bit whose position in `bus_wdata[4:0]` holds a one and leaves the others unchanged. Reads at 0x18 return zero.
- R4: A read at offset 0x00 returns the control bits in bits 4:0 with all higher bits zero. Write data above bit 4 has no effect on the control register.
- R5: A read at offset 0x04 returns the status code in bits 7:3, with bits 2:0 and bits above 7 zero. Bus writes to 0x04 change nothing.
- R6: When `eng_irq_req` is high while the interrupt flag is clear, the next cycle has the flag set and the status code equal to the `eng_status` value sampled with the request.
- R7: While the interrupt flag is set, engine requests are ignored and the status code does not change.
- R8: If a clear-port write with bit 1 set coincides with an engine request, the clear wins. The flag stays clear and the status code is not updated.
- R9: `irq` is high exactly when both the interrupt flag and the interface-enable bit are set.
- R10: Offset 0x08 is a read/write byte in bits 7:0 that drives `tx_data`. A high `eng_rx_valid` loads `eng_rx_data` into it, and this load takes precedence over a bus write in the same cycle.
- R11: Offset 0x0C is a read/write byte. Bits 7:1 drive `own_addr` and bit 0 drives `gc_en`.
- R12: Reads at unmapped offsets (0x10, 0x14, 0x1C) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt to the processor |
| eng_status | input | CODE_W (5) | Bus-state code from the engine |
| eng_irq_req | input | 1 | Engine request to raise the interrupt flag |
| eng_rx_valid | input | 1 | Loads the received byte into the data register |
| eng_rx_data | input | 8 | Received byte |
| ctl_bits | output | 5 | Current control register |
| tx_data | output | 8 | Data register contents |
| own_addr | output | 7 | Own slave address |
| gc_en | output | 1 | General-call response enable |

## Verification
Every write, engine request and receive load becomes visible at the outputs and in `bus_rdata` one clock edge after it is presented. Read data and `irq` follow the register state combinationally in that same cycle. The bench therefore drives inputs on the falling edge. Its reference model updates right after the next rising edge, using the values it drove. It compares every output on the following falling edge, so each result is sampled exactly one edge after its cause.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
  localparam int CTRL_W   = 5;
  localparam int CB_ACK   = 0;
  localparam int CB_FLAG  = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_START = 3;
  localparam int CB_EN    = 4;

  localparam int OFS_SET  = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_DATA = 'h08;
  localparam int OFS_ADR  = 'h0C;
  localparam int OFS_CLR  = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_ADR, SEL_CLR
  } reg_sel_e;

  // One control bit: set mask first, clear mask on top so clear wins.
  function automatic logic ctrl_bit_next(input logic cur, input logic s, input logic c);
    return (cur | s) & ~c;
  endfunction
endpackage

// File: rtl/i2c_regif_decode.sv
module i2c_regif_decode
  import i2c_regif_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_data,
  output logic              wr_adr
);
  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFS_SET))  return SEL_CTRL;
    if (a == ADDR_W'(OFS_STAT)) return SEL_STAT;
    if (a == ADDR_W'(OFS_DATA)) return SEL_DATA;
    if (a == ADDR_W'(OFS_ADR))  return SEL_ADR;
    if (a == ADDR_W'(OFS_CLR))  return SEL_CLR;
    return SEL_NONE;
  endfunction

  assign sel     = decode(addr);
  assign wr_set  = wr && (sel == SEL_CTRL);
  assign wr_clr  = wr && (sel == SEL_CLR);
  assign wr_data = wr && (sel == SEL_DATA);
  assign wr_adr  = wr && (sel == SEL_ADR);
endmodule

// File: rtl/i2c_regif_ctrl.sv
module i2c_regif_ctrl
  import i2c_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] set_mask,
  input  logic [CTRL_W-1:0] clr_mask,
  input  logic              cap_fire,
  output logic [CTRL_W-1:0] ctl_q
);
  logic [CTRL_W-1:0] set_all;

  always_comb begin
    set_all = set_mask;
    set_all[CB_FLAG] = set_mask[CB_FLAG] | cap_fire;
  end

  for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[i] <= 1'b0;
      else        ctl_q[i] <= ctrl_bit_next(ctl_q[i], set_all[i], clr_mask[i]);
    end
  end
endmodule

// File: rtl/i2c_regif_stat.sv
module i2c_regif_stat #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CODE_W-1:0] code_in,
  input  logic              flag_q,
  input  logic              flag_clr,
  output logic              cap_fire,
  output logic [CODE_W-1:0] code_q
);
  // Capture only when the flag is about to rise.
  assign cap_fire = req && !flag_q && !flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '1;
    else if (cap_fire) code_q <= code_in;
  end
endmodule

// File: rtl/i2c_regif.sv
module i2c_regif
  import i2c_regif_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CODE_W = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic [CODE_W-1:0] eng_status,
  input  logic              eng_irq_req,
  input  logic              eng_rx_valid,
  input  logic [BYTE_W-1:0] eng_rx_data,
  output logic [CTRL_W-1:0] ctl_bits,
  output logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-2:0] own_addr,
  output logic              gc_en
);
  localparam int STAT_LSB = BYTE_W - CODE_W;

  reg_sel_e          sel;
  logic              set_hit, clr_hit, wr_data, wr_adr;
  logic [CTRL_W-1:0] set_mask, clr_mask, ctl_q;
  logic              cap_fire;
  logic [CODE_W-1:0] code_q;
  logic [BYTE_W-1:0] data_q, adr_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BYTE_W];

  i2c_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .sel(sel),
    .wr_set(set_hit), .wr_clr(clr_hit), .wr_data(wr_data), .wr_adr(wr_adr)
  );

  assign set_mask = set_hit ? bus_wdata[CTRL_W-1:0] : '0;
  assign clr_mask = clr_hit ? bus_wdata[CTRL_W-1:0] : '0;

  i2c_regif_stat #(.CODE_W(CODE_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .req(eng_irq_req), .code_in(eng_status),
    .flag_q(ctl_q[CB_FLAG]), .flag_clr(clr_mask[CB_FLAG]),
    .cap_fire(cap_fire), .code_q(code_q)
  );

  i2c_regif_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .cap_fire(cap_fire), .ctl_q(ctl_q)
  );

  // Data byte: an engine receive load beats a bus write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            data_q <= '0;
    else if (eng_rx_valid) data_q <= eng_rx_data;
    else if (wr_data)      data_q <= bus_wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adr_q <= '0;
    else if (wr_adr) adr_q <= bus_wdata[BYTE_W-1:0];
  end

  function automatic logic [DATA_W-1:0] stat_word(input logic [CODE_W-1:0] c);
    return DATA_W'({c, {STAT_LSB{1'b0}}});
  endfunction

  always_comb begin
    case (sel)
      SEL_CTRL: bus_rdata = DATA_W'(ctl_q);
      SEL_STAT: bus_rdata = stat_word(code_q);
      SEL_DATA: bus_rdata = DATA_W'(data_q);
      SEL_ADR:  bus_rdata = DATA_W'(adr_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq      = ctl_q[CB_FLAG] & ctl_q[CB_EN];
  assign ctl_bits = ctl_q;
  assign tx_data  = data_q;
  assign own_addr = adr_q[BYTE_W-1:1];
  assign gc_en    = adr_q[0];
endmodule

// File: rtl/i2c_regif_chk.sv
module i2c_regif_chk
  import i2c_regif_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              set_hit,
  input logic              clr_hit,
  input logic              eng_irq_req,
  input logic [CODE_W-1:0] eng_status,
  input logic [CTRL_W-1:0] ctl_bits,
  input logic [CODE_W-1:0] code_q,
  input logic              irq
);
  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((ctl_bits & $past(bus_wdata[CTRL_W-1:0])) == $past(bus_wdata[CTRL_W-1:0])));

  assert_stat_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_STAT)) |-> (bus_rdata[2:0] == 3'b000));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_irq_req && !ctl_bits[CB_FLAG] && !(clr_hit && bus_wdata[CB_FLAG]))
      |=> (ctl_bits[CB_FLAG] && code_q == $past(eng_status)));

  assert_status_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[CB_FLAG] && $past(ctl_bits[CB_FLAG])) |-> $stable(code_q));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && bus_wdata[CB_FLAG]) |=> !ctl_bits[CB_FLAG]);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_bits[CB_FLAG]) && ctl_bits[CB_EN]) |-> irq);
endmodule

bind i2c_regif i2c_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .bus_wdata(bus_wdata), .set_hit(set_hit), .clr_hit(clr_hit),
  .eng_irq_req(eng_irq_req), .eng_status(eng_status), .ctl_bits(ctl_bits),
  .code_q(code_q), .irq(irq)
);

// File: tb/i2c_regif_bench.sv
module i2c_regif_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [4:0]  eng_status = '0;
  logic        eng_irq_req = 1'b0;
  logic        eng_rx_valid = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic [4:0]  ctl_bits;
  logic [7:0]  tx_data;
  logic [6:0]  own_addr;
  logic        gc_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int m_ctrl, m_code, m_data, m_adr;

  always #(CLK_P/2) clk = ~clk;

  i2c_regif u_i2c_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_status(eng_status), .eng_irq_req(eng_irq_req),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .ctl_bits(ctl_bits), .tx_data(tx_data), .own_addr(own_addr), .gc_en(gc_en)
  );

  function automatic int exp_read(int a);
    case (a)
      'h00: return m_ctrl;
      'h04: return m_code * 8;
      'h08: return m_data;
      'h0C: return m_adr;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rdata", bus_rdata, exp_read(int'(bus_addr)));
    chk(tag, "irq", irq, ((m_ctrl >> 1) & (m_ctrl >> 4) & 1));
    chk(tag, "ctl_bits", ctl_bits, m_ctrl);
    chk(tag, "tx_data", tx_data, m_data);
    chk(tag, "own_addr", own_addr, m_adr >> 1);
    chk(tag, "gc_en", gc_en, m_adr & 1);
  endtask

  // One bus/engine cycle; result compared one edge later.
  task automatic cyc(bit wr, int a, int wd, bit rq, int st, bit rv, int rd, string tag);
    int clr, set;
    bit cap;
    bus_wr = wr; bus_addr = 5'(a); bus_wdata = 32'(wd);
    eng_irq_req = rq; eng_status = 5'(st);
    eng_rx_valid = rv; eng_rx_data = 8'(rd);
    @(posedge clk);
    clr = (wr && a == 'h18) ? (wd & 'h1F) : 0;
    set = (wr && a == 'h00) ? (wd & 'h1F) : 0;
    cap = rq && !((m_ctrl >> 1) & 1) && !((clr >> 1) & 1);
    if (cap) begin set = set | 2; m_code = st & 'h1F; end
    m_ctrl = (m_ctrl | set) & ~clr & 'h1F;
    if (rv) m_data = rd & 'hFF;
    else if (wr && a == 'h08) m_data = wd & 'hFF;
    if (wr && a == 'h0C) m_adr = wd & 'hFF;
    @(negedge clk);
    bus_wr = 0; eng_irq_req = 0; eng_rx_valid = 0;
    compare(tag);
  endtask

  task automatic rd(int a, string tag);
    cyc(0, a, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ctrl = 0; m_code = 'h1F; m_data = 0; m_adr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd('h00, "R1"); rd('h04, "R1"); rd('h08, "R1"); rd('h0C, "R1");
    // R2 set port
    cyc(1, 'h00, 'h15, 0, 0, 0, 0, "R2");
    cyc(1, 'h00, 'h0A, 0, 0, 0, 0, "R2");
    // R3 clear port and its read value
    cyc(1, 'h18, 'h06, 0, 0, 0, 0, "R3");
    rd('h18, "R3");
    cyc(1, 'h18, 'h1F, 0, 0, 0, 0, "R3");
    // R4 upper write bits ignored
    cyc(1, 'h00, 'hFFFFFF00, 0, 0, 0, 0, "R4");
    rd('h00, "R4");
    // R5 status read-only
    cyc(1, 'h04, 'h00, 0, 0, 0, 0, "R5");
    rd('h04, "R5");
    // R6/R9 capture with enable set
    cyc(1, 'h00, 'h10, 0, 0, 0, 0, "R9");
    cyc(0, 'h04, 0, 1, 'h0B, 0, 0, "R6");
    // R7 frozen while pending
    cyc(0, 'h04, 0, 1, 'h03, 0, 0, "R7");
    cyc(1, 'h00, 'h02, 1, 'h07, 0, 0, "R7");
    // R8 clear beats a coincident request
    cyc(1, 'h18, 'h02, 1, 'h05, 0, 0, "R8");
    rd('h04, "R8");
    // R9 flag without enable, then enable
    cyc(1, 'h18, 'h10, 0, 0, 0, 0, "R9");
    cyc(0, 'h04, 0, 1, 'h05, 0, 0, "R9");
    cyc(1, 'h00, 'h10, 0, 0, 0, 0, "R9");
    cyc(1, 'h18, 'h12, 0, 0, 0, 0, "R9");
    // R10 data register
    cyc(1, 'h08, 'h1C3, 0, 0, 0, 0, "R10");
    cyc(0, 'h08, 0, 0, 0, 1, 'h5A, "R10");
    cyc(1, 'h08, 'h77, 0, 0, 1, 'h3E, "R10");
    // R11 address register
    cyc(1, 'h0C, 'hA5, 0, 0, 0, 0, "R11");
    cyc(1, 'h0C, 'h34, 0, 0, 0, 0, "R11");
    // R12 unmapped offsets
    cyc(1, 'h10, 'hFF, 0, 0, 0, 0, "R12");
    cyc(1, 'h14, 'hFF, 0, 0, 0, 0, "R12");
    cyc(1, 'h1C, 'hFF, 0, 0, 0, 0, "R12");
    rd('h10, "R12");
    // mixed traffic against the model
    begin
      int lf = 'h1ACE1;
      for (int i = 0; i < 400; i++) begin
        int offs[8] = '{'h00, 'h04, 'h08, 'h0C, 'h18, 'h10, 'h00, 'h18};
        lf = (lf >> 1) ^ ((lf & 1) ? 'hB400 : 0);
        cyc(lf[0], offs[(lf >> 1) & 7], lf * 7, lf[4], lf >> 5, lf[10] & lf[11],
            lf >> 3, "R7");
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule